// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Requester

This block is the processor-side master of a 32-bit system bus on which the same wires carry an address in one cycle and data in later cycles. An internal client hands it one request at a time: either a single-datum read or write of 1 to 8 bytes, or an 8-word block read or write. The block drives an address cycle, waits for the device's matching ready handshake, and then runs the data cycles. Write words go out at a rate set by a pacing pattern that is latched while reset is held. Read words are taken whenever the device marks one valid.

Every cycle the master drives carries a 9-bit command that tags it as an address or a data cycle. The command also has a parity bit, and each byte of the bus has its own parity bit. Incoming read words are checked against their byte parity. A mismatch raises a sticky error flag, and the word is still handed to the client.

Top module: `sysbus_requester`

## Requirements
- R1: While reset is held and right after it is released, `req_ready_o` is 1, `drive_o` is 0 and `par_err_o` is 0.
- R2: The first cycle after a request is accepted is an address cycle with `drive_o`=1 and `ad_o` equal to the request address. Its command has bit 8 = 0, bits 7:5 = 3'b001 for a read or 3'b010 for a write, bit 4 = 1 for a block, bit 3 = 0, and bits 2:0 = byte count minus one for a single transfer or 3'd7 for a block.
- R3: The address cycle repeats with the same address while the ready input for its direction (`wr_ready_i` for writes, `rd_ready_i` for reads) is low. The ready input of the other direction has no effect.
- R4: A block moves 8 words. A single transfer of N bytes starting at byte offset o (address bits 1:0) moves ((o + N - 1) >> 2) + 1 words.
- R5: On each write data cycle, `wdata_take_o`=1, `drive_o`=1, `ad_o` equals `wdata_i`, and the command is {1'b1, last, 7'b0}, where last is 1 only on the final word.
- R6: Write pacing uses a 4-bit pattern captured from `pace_mode_i` while reset is low. The cycles after the address cycle step through the pattern from bit 0, and bit 3 wraps back to bit 0. A 1 means a data cycle and a 0 means an idle cycle with `drive_o`=0. An all-zero pattern means a data cycle every cycle.
- R7: In the read data phase, `drive_o` is 0. Any cycle with `rd_valid_i`=1 delivers `ad_i` on `rdata_o` with `rdata_valid_o`=1 in that same cycle, and `rdata_last_o`=1 on the final word.
- R8: Whenever `drive_o`=1, each `ad_chk_o[b]` is the even parity of byte b of `ad_o`, and `cmd_par_o` is the even parity of `cmd_o`.
- R9: A read word whose `ad_chk_i` differs from the even parity of its bytes is still delivered. It sets `par_err_o` from the next cycle on, and only reset clears the flag.
- R10: `req_ready_o` is 1 only while the block is idle. A `req_valid_i` raised during a transfer is ignored and does not start a new address cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; pacing pattern captured while low |
| pace_mode_i | input | 4 | Write pacing pattern, bit 0 first |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_block_i | input | 1 | 1 = 8-word block, 0 = single datum |
| req_size_i | input | 3 | Single-datum byte count minus one |
| req_addr_i | input | 32 | Request address |
| req_ready_o | output | 1 | Idle, request taken this cycle |
| wdata_i | input | 32 | Next write word |
| wdata_take_o | output | 1 | Current write word consumed |
| rdata_o | output | 32 | Read word |
| rdata_valid_o | output | 1 | Read word valid |
| rdata_last_o | output | 1 | Final read word |
| par_err_o | output | 1 | Sticky read parity error |
| ad_o | output | 32 | Bus address/data out |
| ad_chk_o | output | 4 | Per-byte parity out |
| cmd_o | output | 9 | Command out |
| cmd_par_o | output | 1 | Command parity out |
| drive_o | output | 1 | Master drives bus this cycle |
| ad_i | input | 32 | Bus data in |
| ad_chk_i | input | 4 | Per-byte parity in |
| rd_valid_i | input | 1 | Device marks read word valid |
| rd_ready_i | input | 1 | Device accepts a read request |
| wr_ready_i | input | 1 | Device accepts a write request |

## Verification
The bench targets these corner cases:
- Single transfers that cross a word boundary, such as 2 bytes at offset 3 or 8 bytes at offset 2. A wrong word count there gives too few or too many data cycles, or puts the last-word flag on the wrong cycle.
- An address cycle held against the ready input of its own direction while the other ready input is high. A design that decodes the handshake wrongly drops the address early.
- The two-on/two-off pacing pattern and the all-zero pattern. These expose a pacer that starts at the wrong phase or hangs with no data slot.
- A read word with bad parity. It must still be delivered, and it must leave a flag that survives later clean transfers.
- Requests raised during a transfer. These must not start a stray address cycle.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } sbr_state_e;

    localparam logic [2:0] KIND_RD = 3'b001;
    localparam logic [2:0] KIND_WR = 3'b010;
endpackage

// File: rtl/sbr_parity.sv
module sbr_parity #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] data_i,
    output logic [BYTES-1:0]   chk_o
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign chk_o[b] = ^data_i[8*b +: 8];
    end
endmodule

// File: rtl/sbr_pacer.sv
module sbr_pacer #(
    parameter int PACE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PACE_W-1:0] mode_i,
    input  logic              clr_i,
    input  logic              adv_i,
    output logic              slot_o
);
    localparam int IDX_W = (PACE_W > 1) ? $clog2(PACE_W) : 1;

    logic [PACE_W-1:0] pat_q;
    logic [IDX_W-1:0]  idx_d, idx_q;

    // pattern captured synchronously for as long as reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) pat_q <= mode_i;
    end

    always_comb begin
        idx_d = idx_q;
        if (clr_i) begin
            idx_d = '0;
        end else if (adv_i) begin
            if (idx_q == IDX_W'(PACE_W - 1)) idx_d = '0;
            else                             idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign slot_o = (pat_q == '0) || pat_q[idx_q];
endmodule

// File: rtl/sysbus_requester.sv
module sysbus_requester
    import sbr_pkg::*;
#(
    parameter int DW          = 32,
    parameter int BLOCK_WORDS = 8,
    parameter int PACE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PACE_W-1:0] pace_mode_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_block_i,
    input  logic [2:0]        req_size_i,
    input  logic [DW-1:0]     req_addr_i,
    output logic              req_ready_o,
    input  logic [DW-1:0]     wdata_i,
    output logic              wdata_take_o,
    output logic [DW-1:0]     rdata_o,
    output logic              rdata_valid_o,
    output logic              rdata_last_o,
    output logic              par_err_o,
    output logic [DW-1:0]     ad_o,
    output logic [DW/8-1:0]   ad_chk_o,
    output logic [8:0]        cmd_o,
    output logic              cmd_par_o,
    output logic              drive_o,
    input  logic [DW-1:0]     ad_i,
    input  logic [DW/8-1:0]   ad_chk_i,
    input  logic              rd_valid_i,
    input  logic              rd_ready_i,
    input  logic              wr_ready_i
);
    localparam int BYTES = DW / 8;
    localparam int OFS_W = $clog2(BYTES);
    localparam int CNT_W = $clog2(BLOCK_WORDS + 1);
    localparam int SUM_W = OFS_W + 4;

    typedef struct packed {
        sbr_state_e       state;
        logic             write;
        logic             block;
        logic [2:0]       size;
        logic [DW-1:0]    addr;
        logic [CNT_W-1:0] words;
        logic [CNT_W-1:0] cnt;
        logic             perr;
    } regs_t;

    regs_t q, d;

    logic             slot;
    logic [BYTES-1:0] rd_chk_calc;
    logic             last_word;
    logic [SUM_W-1:0] span;

    sbr_pacer #(.PACE_W(PACE_W)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (pace_mode_i),
        .clr_i  (q.state == ST_ADDR),
        .adv_i  (q.state == ST_WDATA),
        .slot_o (slot)
    );

    sbr_parity #(.BYTES(BYTES)) u_par_out (.data_i(ad_o), .chk_o(ad_chk_o));
    sbr_parity #(.BYTES(BYTES)) u_par_in  (.data_i(ad_i), .chk_o(rd_chk_calc));

    assign span      = SUM_W'(req_addr_i[OFS_W-1:0]) + SUM_W'(req_size_i);
    assign last_word = (q.cnt == q.words - 1'b1);

    always_comb begin
        d             = q;
        req_ready_o   = (q.state == ST_IDLE);
        drive_o       = 1'b0;
        ad_o          = '0;
        cmd_o         = '0;
        wdata_take_o  = 1'b0;
        rdata_valid_o = 1'b0;
        rdata_last_o  = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.state = ST_ADDR;
                    d.write = req_write_i;
                    d.block = req_block_i;
                    d.size  = req_size_i;
                    d.addr  = req_addr_i;
                    d.cnt   = '0;
                    d.words = req_block_i ? CNT_W'(BLOCK_WORDS)
                                          : CNT_W'((span >> OFS_W) + 1'b1);
                end
            end
            ST_ADDR: begin
                drive_o = 1'b1;
                ad_o    = q.addr;
                cmd_o   = {1'b0, (q.write ? KIND_WR : KIND_RD), q.block, 1'b0,
                           (q.block ? 3'(BLOCK_WORDS - 1) : q.size)};
                if (q.write ? wr_ready_i : rd_ready_i)
                    d.state = q.write ? ST_WDATA : ST_RDATA;
            end
            ST_WDATA: begin
                if (slot) begin
                    drive_o      = 1'b1;
                    wdata_take_o = 1'b1;
                    ad_o         = wdata_i;
                    cmd_o        = {1'b1, last_word, 7'b0};
                    d.cnt        = q.cnt + 1'b1;
                    if (last_word) d.state = ST_IDLE;
                end
            end
            ST_RDATA: begin
                if (rd_valid_i) begin
                    rdata_valid_o = 1'b1;
                    rdata_last_o  = last_word;
                    d.cnt         = q.cnt + 1'b1;
                    if (ad_chk_i != rd_chk_calc) d.perr = 1'b1;
                    if (last_word) d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cmd_par_o = ^cmd_o;
    assign rdata_o   = ad_i;
    assign par_err_o = q.perr;

    // R3: address cycle held while its own ready is low
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o && !cmd_o[8] && !(cmd_o[6] ? wr_ready_i : rd_ready_i))
        |=> (drive_o && !cmd_o[8] && $stable(ad_o)));

    // R5: a consumed write word is a driven data cycle
    p_take_is_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_take_o |-> (drive_o && cmd_o[8]));

    // R7: bus not driven while read words arrive
    p_read_undriven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid_o |-> !drive_o);

    // R8: even parity over command and its check bit
    p_cmd_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> ((^{cmd_o, cmd_par_o}) == 1'b0));

    // R9: error flag is sticky
    p_sticky_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |=> par_err_o);

    // R10: ready only while bus is quiet
    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (!drive_o && !rdata_valid_o));
endmodule

// File: tb/tb_sysbus_requester.sv
module tb_sysbus_requester;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pace_mode_i = 4'b1111;
    logic        req_valid_i = 0, req_write_i = 0, req_block_i = 0;
    logic [2:0]  req_size_i = 0;
    logic [31:0] req_addr_i = 0;
    logic        req_ready_o;
    logic [31:0] wdata_i = 0;
    logic        wdata_take_o;
    logic [31:0] rdata_o;
    logic        rdata_valid_o, rdata_last_o, par_err_o;
    logic [31:0] ad_o;
    logic [3:0]  ad_chk_o;
    logic [8:0]  cmd_o;
    logic        cmd_par_o, drive_o;
    logic [31:0] ad_i = 0;
    logic [3:0]  ad_chk_i = 0;
    logic        rd_valid_i = 0, rd_ready_i = 1, wr_ready_i = 1;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] cur_mode = 4'b1111;

    always #2 clk = ~clk;

    sysbus_requester dut (.*);

    // {write, block, size_m1[2:0], addr[31:0], words[3:0]}
    localparam int NV = 7;
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 1'b0, 3'd3, 32'h1000_0000, 4'd1},
        {1'b1, 1'b0, 3'd0, 32'h2000_0003, 4'd1},
        {1'b1, 1'b0, 3'd7, 32'h3000_0000, 4'd2},
        {1'b0, 1'b0, 3'd7, 32'h4000_0006, 4'd3},
        {1'b0, 1'b1, 3'd0, 32'h5000_0020, 4'd8},
        {1'b1, 1'b1, 3'd0, 32'h6000_0040, 4'd8},
        {1'b1, 1'b0, 3'd1, 32'h0000_0003, 4'd2}
    };

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] par4(input logic [31:0] v);
        logic [3:0] r;
        for (int b = 0; b < 4; b++) r[b] = ^v[8*b +: 8];
        return r;
    endfunction

    function automatic logic [8:0] addr_cmd(input bit w, input bit blk, input logic [2:0] sz);
        return {1'b0, (w ? 3'b010 : 3'b001), blk, 1'b0, (blk ? 3'd7 : sz)};
    endfunction

    task automatic do_reset(input logic [3:0] mode);
        @(negedge clk);
        rst_n = 1'b0;
        pace_mode_i = mode;
        cur_mode = mode;
        repeat (3) @(negedge clk);
        #1;
        check(req_ready_o == 1'b1 && drive_o == 1'b0 && par_err_o == 1'b0,
              "R1 in reset", {req_ready_o, drive_o, par_err_o}, 3'b100);
        rst_n = 1'b1;
        pace_mode_i = ~mode;  // changes after reset must not matter (R6)
    endtask

    task automatic run_txn(input bit w, input bit blk, input logic [2:0] sz,
                           input logic [31:0] addr, input int words, input int hold,
                           input int bad_k, input bit gaps, input bit noise);
        int cyc;
        int k;
        logic [31:0] word;
        bit slot;
        bit rv;
        @(negedge clk);
        req_valid_i = 1; req_write_i = w; req_block_i = blk;
        req_size_i = sz; req_addr_i = addr;
        #1;
        check(req_ready_o == 1'b1, "R10 ready when idle", 64'(req_ready_o), 1);
        @(negedge clk);
        req_valid_i = 0;
        if (hold > 0) begin
            if (w) begin wr_ready_i = 0; rd_ready_i = 1; end
            else   begin rd_ready_i = 0; wr_ready_i = 1; end
        end
        for (int h = 0; h <= hold; h++) begin
            #1;
            check(drive_o && ad_o == addr, "R2/R3 address cycle", {drive_o, ad_o}, {1'b1, addr});
            check(cmd_o == addr_cmd(w, blk, sz), "R2 address command", 64'(cmd_o), 64'(addr_cmd(w, blk, sz)));
            check(ad_chk_o == par4(ad_o) && cmd_par_o == ^cmd_o, "R8 address parity",
                  {ad_chk_o, cmd_par_o}, {par4(ad_o), ^cmd_o});
            if (h < hold) begin
                @(negedge clk);
                if (h == hold - 1) begin wr_ready_i = 1; rd_ready_i = 1; end
            end
        end
        cyc = 0; k = 0;
        while (k < words && cyc < 64) begin
            @(negedge clk);
            req_valid_i = noise;
            req_addr_i  = 32'hDEAD_0000;
            wdata_i = 32'hA500_0000 + 32'(k * 32'h0101_0101);
            word    = 32'h3C00_0000 + 32'(k * 32'h0011_2233);
            rv      = w ? 1'b0 : (gaps ? ((cyc % 3) != 1) : 1'b1);
            rd_valid_i = rv;
            ad_i     = word;
            ad_chk_i = par4(word) ^ ((k == bad_k) ? 4'b0001 : 4'b0000);
            #1;
            if (noise) check(req_ready_o == 1'b0, "R10 busy", 64'(req_ready_o), 0);
            if (w) begin
                slot = (cur_mode == 4'b0000) || cur_mode[cyc % 4];
                check(wdata_take_o == slot, "R6 pacing slot", 64'(wdata_take_o), 64'(slot));
                if (slot) begin
                    check(drive_o && ad_o == wdata_i, "R5 write word", {drive_o, ad_o}, {1'b1, wdata_i});
                    check(cmd_o == {1'b1, (k == words - 1), 7'b0}, "R4/R5 data command",
                          64'(cmd_o), 64'({1'b1, (k == words - 1), 7'b0}));
                    check(ad_chk_o == par4(ad_o) && cmd_par_o == ^cmd_o, "R8 data parity",
                          {ad_chk_o, cmd_par_o}, {par4(ad_o), ^cmd_o});
                    k++;
                end else begin
                    check(drive_o == 1'b0, "R6 idle slot", 64'(drive_o), 0);
                end
            end else begin
                check(drive_o == 1'b0, "R7 bus released", 64'(drive_o), 0);
                check(rdata_valid_o == rv, "R7 read valid", 64'(rdata_valid_o), 64'(rv));
                if (rv) begin
                    check(rdata_o == word, "R7/R9 read word", 64'(rdata_o), 64'(word));
                    check(rdata_last_o == (k == words - 1), "R4/R7 last word",
                          64'(rdata_last_o), 64'(k == words - 1));
                    k++;
                end
            end
            cyc++;
        end
        @(negedge clk);
        req_valid_i = 0; rd_valid_i = 0;
        #1;
        check(req_ready_o == 1'b1 && drive_o == 1'b0, "R4/R10 back to idle",
              {req_ready_o, drive_o}, 2'b10);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        do_reset(4'b1111);
        @(negedge clk); #1;
        check(req_ready_o && !drive_o && !par_err_o, "R1 after release",
              {req_ready_o, drive_o, par_err_o}, 3'b100);

        // table walk: R2 R4 R5 R7 R8
        for (int i = 0; i < NV; i++) begin
            run_txn(VEC[i][40], VEC[i][39], VEC[i][38:36], VEC[i][35:4],
                    int'(VEC[i][3:0]), 0, -1, 1'b1, 1'b0);
        end

        // R3: hold the address against its own ready, other ready high
        run_txn(1'b1, 1'b0, 3'd3, 32'h7000_0010, 1, 3, -1, 1'b0, 1'b0);
        run_txn(1'b0, 1'b0, 3'd3, 32'h7100_0010, 1, 2, -1, 1'b0, 1'b0);

        // R10: requests during a transfer are ignored
        run_txn(1'b1, 1'b1, 3'd0, 32'h7200_0000, 8, 0, -1, 1'b0, 1'b1);
        run_txn(1'b0, 1'b0, 3'd7, 32'h7300_0004, 2, 0, -1, 1'b1, 1'b1);

        // R6: two data, two idle
        do_reset(4'b0011);
        run_txn(1'b1, 1'b1, 3'd0, 32'h8000_0000, 8, 0, -1, 1'b0, 1'b0);
        run_txn(1'b1, 1'b0, 3'd7, 32'h8100_0002, 3, 0, -1, 1'b0, 1'b0);

        // R6: all-zero pattern means every cycle
        do_reset(4'b0000);
        run_txn(1'b1, 1'b1, 3'd0, 32'h9000_0000, 8, 0, -1, 1'b0, 1'b0);

        // R9: bad parity word delivered, sticky flag
        do_reset(4'b1111);
        run_txn(1'b0, 1'b1, 3'd0, 32'hB000_0000, 8, 0, 5, 1'b0, 1'b0);
        check(par_err_o == 1'b1, "R9 flag set", 64'(par_err_o), 1);
        run_txn(1'b0, 1'b0, 3'd3, 32'hB100_0000, 1, 0, -1, 1'b0, 1'b0);
        check(par_err_o == 1'b1, "R9 flag sticky", 64'(par_err_o), 1);
        do_reset(4'b1111);
        @(negedge clk); #1;
        check(par_err_o == 1'b0, "R9 cleared by reset", 64'(par_err_o), 0);
        run_txn(1'b0, 1'b0, 3'd1, 32'hB200_0001, 1, 0, -1, 1'b0, 1'b0);
        check(par_err_o == 1'b0, "R9 clean read no flag", 64'(par_err_o), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule